// File: doc/BRIEF.md
# Clear-on-Compare Timer with Toggle Output

An 8-bit up-counter that advances on prescaler ticks and compares its value against a programmable TOP register. With the waveform-mode field set to the clear-on-compare code, the count returns to zero on the tick after it equals TOP, so TOP sets the count period. In any other waveform mode the counter runs freely from 0x00 to 0xFF and wraps, and TOP still produces a compare match.

Every compare match sets a sticky flag. The flag drives an interrupt request when the interrupt enable is set. A waveform level can be set to invert on every match, and it reaches the pin only when the direction bit selects output. The TOP register has no shadow copy: a write takes effect at once. If software lowers TOP below the running count, the counter misses that match and runs on through 0xFF before it can match again.

Top module: `ctc_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the count, TOP, match flag, waveform level and all configuration fields to zero. `irq`, `pin_out` and `pin_oe` are then low.
- R2: The count changes only at edges where `tick_en` is high. At all other edges it holds its value.
- R3: With `cfg_wave_mode` equal to 3'd2, a tick taken while the count equals TOP loads 0x00. Any other tick adds one.
- R4: With any other `cfg_wave_mode` value, the count ignores TOP and steps 0xFF to 0x00. A tick taken while the count equals TOP still counts as a compare match.
- R5: A compare match is a tick taken while the count equals TOP. It sets `match_flag` at that edge, and the flag stays set until it is cleared.
- R6: `flag_clr` high at an edge clears `match_flag`. If a compare match happens at the same edge, the flag is set instead.
- R7: `irq` is high exactly when `match_flag` and the stored interrupt enable are both high.
- R8: A TOP write (`top_wr`) takes effect at its edge, and the next comparison uses the new value. When the new TOP is below the count, no match occurs until the count passes 0xFF, wraps to 0x00 and reaches the new TOP.
- R9: With `cfg_out_mode` equal to 2'd1, `wave_lvl` inverts on every compare match. Any other value leaves `wave_lvl` unchanged on a match.
- R10: When the stored direction bit is 1, `pin_oe` is 1 and `pin_out` follows `wave_lvl`. When the bit is 0, both `pin_oe` and `pin_out` are 0.
- R11: With clear-on-compare mode, toggle mode and TOP equal to 0x00, `wave_lvl` inverts on every tick, so its period is two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler clock-enable; one count step per high cycle |
| top_wr | input | 1 | Write strobe for TOP |
| top_wdata | input | 8 | New TOP value |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_wave_mode | input | 3 | Waveform mode; 3'd2 selects clear-on-compare |
| cfg_out_mode | input | 2 | Output mode; 2'd1 selects toggle on match |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_pin_dir | input | 1 | Pin direction; 1 drives the waveform onto the pin |
| flag_clr | input | 1 | Clears the match flag |
| count | output | 8 | Current counter value |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |
| wave_lvl | output | 1 | Internal waveform level |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a missed match. It needs a TOP write that lands below a running count, and it then needs a watch over more than two hundred ticks to show that the flag stays low until the count has wrapped. The bench runs the count to 50 under a TOP of 200, clears the flag and writes TOP = 20. It then steps one tick at a time and counts the ticks until the flag first rises, and it expects exactly 227. The same-edge race between a flag clear and a match is produced with TOP at zero, where every tick is a match.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int CNT_W      = 8;
  localparam int MODE_W     = 3;
  localparam int OUT_W      = 2;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam logic [MODE_W-1:0] CTC_CODE    = MODE_W'(2);
  localparam logic [OUT_W-1:0]  TOGGLE_CODE = OUT_W'(1);

  typedef logic [CNT_W-1:0] cnt_t;

  // compare hit between count and TOP
  function automatic logic cmp_hit(input cnt_t cnt, input cnt_t top);
    return cnt == top;
  endfunction

  // value the counter takes on a tick
  function automatic cnt_t cnt_step(input cnt_t cnt, input cnt_t top, input logic clr_on_top);
    if (clr_on_top && cmp_hit(cnt, top)) return '0;
    return cnt + cnt_t'(1);
  endfunction
endpackage

// File: rtl/ctc_counter.sv
module ctc_counter
  import ctc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             clr_on_top,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit_evt
);
  cnt_t top_q;

  // unbuffered TOP: a write is used by the next comparison
  always_ff @(posedge clk) begin
    if (rst)         top_q <= '0;
    else if (top_wr) top_q <= top_wdata;
  end

  assign hit_evt = tick_en && cmp_hit(cnt_q, top_q);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_step(cnt_q, top_q, clr_on_top);
  end
endmodule

// File: rtl/ctc_flag.sv
module ctc_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (hit_evt) flag_q <= 1'b1;   // set beats clear
    else if (clr_req) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & irq_en;
endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_evt,
  input  logic [OUT_W-1:0] out_mode,
  input  logic             dir_out,
  output logic             lvl_q,
  output logic             pad_o,
  output logic             pad_oe
);
  logic toggle_sel;
  assign toggle_sel = (out_mode == TOGGLE_CODE);

  always_ff @(posedge clk) begin
    if (rst)                          lvl_q <= 1'b0;
    else if (hit_evt && toggle_sel)   lvl_q <= ~lvl_q;
  end

  assign pad_oe = dir_out;
  assign pad_o  = dir_out & lvl_q;
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import ctc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              top_wr,
  input  logic [CNT_W-1:0]  top_wdata,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_wave_mode,
  input  logic [OUT_W-1:0]  cfg_out_mode,
  input  logic              cfg_irq_en,
  input  logic              cfg_pin_dir,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              match_flag,
  output logic              irq,
  output logic              wave_lvl,
  output logic              pin_out,
  output logic              pin_oe
);
  logic [MODE_W-1:0] wave_mode_q;
  logic [OUT_W-1:0]  out_mode_q;
  logic              irq_en_q;
  logic              pin_dir_q;
  logic              ctc_mode;
  logic              match_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_mode_q <= '0;
      out_mode_q  <= '0;
      irq_en_q    <= 1'b0;
      pin_dir_q   <= 1'b0;
    end else if (cfg_wr) begin
      wave_mode_q <= cfg_wave_mode;
      out_mode_q  <= cfg_out_mode;
      irq_en_q    <= cfg_irq_en;
      pin_dir_q   <= cfg_pin_dir;
    end
  end

  assign ctc_mode = (wave_mode_q == CTC_CODE);

  ctc_counter u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clr_on_top(ctc_mode),
    .top_wr(top_wr), .top_wdata(top_wdata),
    .cnt_q(count), .hit_evt(match_evt)
  );

  ctc_flag u_flag (
    .clk(clk), .rst(rst), .hit_evt(match_evt), .clr_req(flag_clr),
    .irq_en(irq_en_q), .flag_q(match_flag), .irq_o(irq)
  );

  ctc_wave u_wave (
    .clk(clk), .rst(rst), .hit_evt(match_evt), .out_mode(out_mode_q),
    .dir_out(pin_dir_q), .lvl_q(wave_lvl), .pad_o(pin_out), .pad_oe(pin_oe)
  );
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk
  import ctc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             ctc_mode,
  input logic             match_evt,
  input logic             flag_clr,
  input logic             match_flag,
  input logic             irq,
  input logic             wave_lvl,
  input logic [OUT_W-1:0] out_mode_q,
  input logic             pin_out,
  input logic             pin_oe,
  input logic [CNT_W-1:0] count
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count));
  // R3
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt && ctc_mode |=> count == '0);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> match_flag);
  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !match_evt |=> !match_flag);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag);
  // R9
  wave_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt && out_mode_q == TOGGLE_CODE |=> wave_lvl != $past(wave_lvl));
  // R9
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !match_evt |=> $stable(wave_lvl));
  // R10
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);
endmodule

bind ctc_timer ctc_timer_chk chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en), .ctc_mode(ctc_mode),
  .match_evt(match_evt), .flag_clr(flag_clr), .match_flag(match_flag),
  .irq(irq), .wave_lvl(wave_lvl), .out_mode_q(out_mode_q),
  .pin_out(pin_out), .pin_oe(pin_oe), .count(count)
);

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       top_wr = 1'b0;
  logic [7:0] top_wdata = '0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wave_mode = '0;
  logic [1:0] cfg_out_mode = '0;
  logic       cfg_irq_en = 1'b0;
  logic       cfg_pin_dir = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] count;
  logic       match_flag, irq, wave_lvl, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ctc_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .top_wr(top_wr), .top_wdata(top_wdata),
    .cfg_wr(cfg_wr), .cfg_wave_mode(cfg_wave_mode), .cfg_out_mode(cfg_out_mode),
    .cfg_irq_en(cfg_irq_en), .cfg_pin_dir(cfg_pin_dir), .flag_clr(flag_clr),
    .count(count), .match_flag(match_flag), .irq(irq), .wave_lvl(wave_lvl),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; edge1(); edge1(); rst = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) edge1();
    tick_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] wm, input logic [1:0] om, input logic ie, input logic dir);
    cfg_wave_mode = wm; cfg_out_mode = om; cfg_irq_en = ie; cfg_pin_dir = dir;
    cfg_wr = 1'b1; edge1(); cfg_wr = 1'b0;
  endtask

  task automatic set_top(input logic [7:0] v);
    top_wdata = v; top_wr = 1'b1; edge1(); top_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; edge1(); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(count, 0, "R1 count");
    check(match_flag, 0, "R1 flag");
    check(wave_lvl, 0, "R1 wave");
    check({irq, pin_out, pin_oe}, 0, "R1 outputs");
    set_cfg(3'd2, 2'd0, 1'b0, 1'b0);
    tick(3);  // TOP reset to 0 keeps a CTC count at zero
    check(count, 0, "R1 top zero");
  endtask

  task automatic t_hold();
    do_reset();
    tick(7);
    for (int i = 0; i < 5; i++) edge1();
    check(count, 7, "R2 hold without tick");
    set_top(8'd3);
    check(count, 7, "R2 hold during top write");
  endtask

  task automatic t_ctc();
    do_reset();
    set_cfg(3'd2, 2'd0, 1'b0, 1'b0);
    set_top(8'd5);
    tick(5);
    check(count, 5, "R3 reaches TOP");
    check(match_flag, 0, "R5 no early flag");
    tick(1);
    check(count, 0, "R3 clear after TOP");
    check(match_flag, 1, "R5 flag on match");
    tick(2);
    check(match_flag, 1, "R5 flag sticky");
    check(count, 2, "R3 restart");
  endtask

  task automatic t_normal();
    do_reset();
    set_top(8'd3);
    tick(3);
    check(match_flag, 0, "R4 before match");
    tick(1);
    check(count, 4, "R4 passes TOP");
    check(match_flag, 1, "R4 flag in free-run");
    tick(251);
    check(count, 255, "R4 reach max");
    tick(1);
    check(count, 0, "R4 wrap");
  endtask

  task automatic t_flag_irq();
    do_reset();
    set_cfg(3'd2, 2'd0, 1'b0, 1'b0);
    tick(1);  // TOP=0: match
    check(match_flag, 1, "R5 set");
    check(irq, 0, "R7 masked");
    set_cfg(3'd2, 2'd0, 1'b1, 1'b0);
    check(irq, 1, "R7 enabled");
    clear_flag();
    check(match_flag, 0, "R6 cleared");
    check(irq, 0, "R7 follows flag");
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check(match_flag, 1, "R6 set wins");
  endtask

  task automatic t_late_write();
    int n = 0;
    do_reset();
    set_cfg(3'd2, 2'd0, 1'b0, 1'b0);
    set_top(8'd200);
    tick(50);
    check(count, 50, "R8 setup");
    set_top(8'd20);
    clear_flag();
    while (!match_flag && n < 400) begin
      tick(1);
      n++;
    end
    check(n, 227, "R8 missed match ticks");
    check(count, 0, "R8 clear at new TOP");
  endtask

  task automatic t_wave();
    int tg = 0;
    logic prev;
    do_reset();
    set_cfg(3'd2, 2'd1, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      prev = wave_lvl;
      tick(1);
      if (wave_lvl != prev) tg++;
    end
    check(tg, 8, "R11 toggle every tick");
    tick(1);
    check(wave_lvl, 1, "R9 toggled level");
    check(pin_out, 1, "R10 pin follows wave");
    check(pin_oe, 1, "R10 oe on");
    set_cfg(3'd2, 2'd2, 1'b0, 1'b0);
    tick(3);
    check(wave_lvl, 1, "R9 other mode holds");
    check({pin_oe, pin_out}, 0, "R10 pin off");
    set_cfg(3'd0, 2'd1, 1'b0, 1'b1);
    set_top(8'd2);
    tick(3);  // match at count 2 in free-run
    check(wave_lvl, 0, "R9 toggle in free-run");
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_ctc();
    t_normal();
    t_flag_irq();
    t_late_write();
    t_wave();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule